// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects `NSRC` external interrupt lines and distributes them to `NCTX` target contexts. A context is one privilege level on one hardware thread, and each context has its own interrupt output. Every line passes through a gateway that turns it into a pending request. Each line can be set as level-sensitive or as rising-edge-sensitive. A request reaches a context only when three conditions hold: the context has enabled that source, the source's priority is above zero, and the priority is above the context's threshold.

Software in a context services a request in two steps. It reads the context's claim register, which returns the winning source ID and takes that request. When the handler is done, it writes the same ID back to the claim register. Until that write-back, the source cannot raise a new request. For edge-sensitive sources, the `QUEUE_EDGES` parameter decides what happens to rising edges that arrive while the source is claimed. In queue mode they are counted, up to `QDEPTH`, and replayed one at a time after each completion. In drop mode they are discarded.

Each source gateway is a three-state machine:
- **IDLE**: no request outstanding.
- **PEND**: a request is waiting to be claimed.
- **ACTIVE**: the request has been claimed and its handler is running.

The transitions are:
- IDLE→PEND on a trigger. A trigger is a high level in level mode, or a rising edge in edge mode.
- PEND→ACTIVE on a claim.
- ACTIVE→PEND on a completion when a re-request exists. That is a still-high line in level mode, or a non-zero edge count in queue mode.
- ACTIVE→IDLE on a completion otherwise.

Top module: `plic_core`

## Requirements
- R1: After reset, every priority, enable bit, threshold and edge-select bit is 0, no source is pending, all `irq_o` bits are low, and every claim read returns 0.
- R2: A source is delivered to a context only if that context's enable word has the source's bit set. Bit k of an enable word is source k, and bit 0 is ignored.
- R3: A claim read returns the eligible source with the highest priority. Among equal priorities it returns the lowest ID. It returns 0 when nothing is eligible. ID 0 never denotes a source.
- R4: A source is eligible for a context only if its priority is strictly greater than that context's threshold. A priority of 0 is never delivered.
- R5: A claim read moves the returned source from pending to claimed in the same clock edge. While claimed, the source is not pending for any context, even if its line stays high or toggles.
- R6: In level mode, a completion re-samples the line. If the line is high, the source becomes pending again at that edge. If it is low, the source returns to idle.
- R7: In edge mode with `QUEUE_EDGES=1`, rising edges seen while the source is claimed are counted. The count saturates at `QDEPTH`. Each completion makes the source pending again and decrements the count, until the count reaches zero.
- R8: In edge mode with `QUEUE_EDGES=0`, rising edges seen while the source is claimed are discarded. A completion always returns the source to idle. A rising edge while the source is already pending is merged, in both modes.
- R9: A completion is a write of a source ID to a context's claim register. It has an effect only if that source is enabled for that context and is currently claimed. Any other completion write changes nothing.
- R10: `irq_o[c]` is a register. It rises one clock after context c first has an eligible source. It falls one clock after context c has no eligible source left.
- R11: The register map uses word addresses. 0x000+k holds the priority of source k (read/write, k=1..NSRC). 0x040 returns the pending bits (read-only, bit k is source k). 0x041 holds the edge-select bits (1 = rising edge). 0x080+c holds the enable word of context c. 0x0C0+c holds the threshold of context c. 0x100+c is the claim register of context c: a read claims, a write completes. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt lines; bit k is source k (range NSRC:1) |
| irq_o | output | NCTX | Registered interrupt request, one per context |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a read of a claim register claims) |
| reg_addr | input | 9 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |

## Verification
The embedded properties assume the register port issues at most one access per cycle, so that at most one claim can occur per edge. They also assume the edge-select bits are not changed while a source is claimed. The stimulus keeps to both assumptions: it never raises `reg_we` and `reg_re` together, and it programs the edge-select bits once, before any line moves. A behavioural model in the bench advances both a queue-mode instance and a drop-mode instance on every edge. The bench compares each instance's interrupt outputs and read data with the model in every cycle.

// File: rtl/plic_pkg.sv
package plic_pkg;
    typedef enum logic [1:0] {
        GW_IDLE   = 2'd0,
        GW_PEND   = 2'd1,
        GW_ACTIVE = 2'd2
    } gw_state_e;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned DATA_W = 32;

    localparam logic [2:0] RGN_PRIO  = 3'd0;
    localparam logic [2:0] RGN_STAT  = 3'd1;
    localparam logic [2:0] RGN_EN    = 3'd2;
    localparam logic [2:0] RGN_THR   = 3'd3;
    localparam logic [2:0] RGN_CLAIM = 3'd4;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
#(
    parameter int unsigned QDEPTH      = 4,
    parameter bit          QUEUE_EDGES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);
    localparam int unsigned CNT_W = $clog2(QDEPTH + 1);

    gw_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             src_q;
    logic             rise, trig;
    logic [CNT_W:0]   cnt_sum;
    logic [CNT_W-1:0] cnt_sat;

    assign rise    = src_i & ~src_q;
    assign trig    = edge_mode_i ? rise : src_i;
    assign cnt_sum = {1'b0, cnt} + {{CNT_W{1'b0}}, rise};
    assign cnt_sat = (cnt_sum > (CNT_W+1)'(QDEPTH)) ? CNT_W'(QDEPTH) : cnt_sum[CNT_W-1:0];

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            GW_IDLE: begin
                if (trig) state_nx = GW_PEND;
            end
            GW_PEND: begin
                if (claim_i) state_nx = GW_ACTIVE;
            end
            GW_ACTIVE: begin
                if (edge_mode_i && QUEUE_EDGES) cnt_nx = cnt_sat;
                if (complete_i) begin
                    if (!edge_mode_i) begin
                        state_nx = src_i ? GW_PEND : GW_IDLE;
                    end else if (cnt_nx != '0) begin
                        state_nx = GW_PEND;
                        cnt_nx   = cnt_nx - 1'b1;
                    end else begin
                        state_nx = GW_IDLE;
                    end
                end
            end
            default: state_nx = GW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GW_IDLE;
            cnt   <= '0;
            src_q <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            src_q <= src_i;
        end
    end

    always_comb begin
        pending_o = (state == GW_PEND);
    end

    p_claim_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |-> state == GW_PEND);

    p_hold_claimed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GW_ACTIVE && !complete_i) |=> !pending_o);

    p_level_replay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GW_ACTIVE && complete_i && !edge_mode_i && src_i) |=> pending_o);

    generate
        if (!QUEUE_EDGES) begin : g_drop_chk
            p_drop_edges_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (state == GW_ACTIVE && complete_i && edge_mode_i) |=> !pending_o);
        end
    endgenerate
endmodule

// File: rtl/plic_target.sv
module plic_target #(
    parameter int unsigned NSRC   = 10,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned ID_W  = $clog2(NSRC + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC:0]                pending_i,
    input  logic [NSRC:0]                enable_i,
    input  logic [NSRC:0][PRIO_W-1:0]    prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              best_id_o,
    output logic                         irq_o
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_id_o = '0;
        best_p    = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (pending_i[s] && enable_i[s] && (prio_i[s] > thr_i) && (prio_i[s] > best_p)) begin
                best_id_o = ID_W'(s);
                best_p    = prio_i[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= (best_id_o != '0);
    end

    p_best_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id_o != '0) |-> (enable_i[best_id_o] && pending_i[best_id_o]));

    p_above_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id_o != '0) |-> (prio_i[best_id_o] > thr_i));

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(best_id_o != '0));
endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_pkg::*;
#(
    parameter int unsigned NSRC        = 10,
    parameter int unsigned NCTX        = 9,
    parameter int unsigned PRIO_W      = 3,
    parameter int unsigned QDEPTH      = 4,
    parameter bit          QUEUE_EDGES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_i,
    output logic [NCTX-1:0]   irq_o,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [8:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int unsigned ID_W = $clog2(NSRC + 1);

    logic [NSRC:0][PRIO_W-1:0] prio_q;
    logic [NSRC:0]             edge_q;
    logic [NCTX-1:0][NSRC:0]   en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;

    logic [NSRC:0]             pending_vec;
    logic [NSRC:0]             claim_vec;
    logic [NSRC:0]             complete_vec;
    logic [NCTX-1:0][ID_W-1:0] best_id;

    logic [2:0] rgn;
    logic [5:0] idx;
    logic       claim_rd, cmp_wr;

    assign rgn      = reg_addr[8:6];
    assign idx      = reg_addr[5:0];
    assign claim_rd = reg_re && (rgn == RGN_CLAIM);
    assign cmp_wr   = reg_we && (rgn == RGN_CLAIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            edge_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (reg_we) begin
            for (int s = 1; s <= NSRC; s++) begin
                if (rgn == RGN_PRIO && idx == 6'(s)) prio_q[s] <= reg_wdata[PRIO_W-1:0];
            end
            if (rgn == RGN_STAT && idx == 6'd1) edge_q <= {reg_wdata[NSRC:1], 1'b0};
            for (int c = 0; c < NCTX; c++) begin
                if (rgn == RGN_EN  && idx == 6'(c)) en_q[c]  <= {reg_wdata[NSRC:1], 1'b0};
                if (rgn == RGN_THR && idx == 6'(c)) thr_q[c] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        claim_vec    = '0;
        complete_vec = '0;
        for (int c = 0; c < NCTX; c++) begin
            for (int s = 1; s <= NSRC; s++) begin
                if (claim_rd && idx == 6'(c) && best_id[c] == ID_W'(s)) claim_vec[s] = 1'b1;
                if (cmp_wr && idx == 6'(c) && reg_wdata == 32'(s) && en_q[c][s]) complete_vec[s] = 1'b1;
            end
        end
    end

    assign pending_vec[0] = 1'b0;

    generate
        for (genvar s = 1; s <= NSRC; s++) begin : g_src
            plic_gateway #(
                .QDEPTH      (QDEPTH),
                .QUEUE_EDGES (QUEUE_EDGES)
            ) u_gw (
                .clk         (clk),
                .rst_n       (rst_n),
                .src_i       (src_i[s]),
                .edge_mode_i (edge_q[s]),
                .claim_i     (claim_vec[s]),
                .complete_i  (complete_vec[s]),
                .pending_o   (pending_vec[s])
            );
        end
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            plic_target #(
                .NSRC   (NSRC),
                .PRIO_W (PRIO_W)
            ) u_tgt (
                .clk       (clk),
                .rst_n     (rst_n),
                .pending_i (pending_vec),
                .enable_i  (en_q[c]),
                .prio_i    (prio_q),
                .thr_i     (thr_q[c]),
                .best_id_o (best_id[c]),
                .irq_o     (irq_o[c])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (rgn)
            RGN_PRIO: begin
                for (int s = 1; s <= NSRC; s++)
                    if (idx == 6'(s)) reg_rdata = 32'(prio_q[s]);
            end
            RGN_STAT: begin
                if (idx == 6'd0) reg_rdata = 32'(pending_vec);
                if (idx == 6'd1) reg_rdata = 32'(edge_q);
            end
            RGN_EN: begin
                for (int c = 0; c < NCTX; c++)
                    if (idx == 6'(c)) reg_rdata = 32'(en_q[c]);
            end
            RGN_THR: begin
                for (int c = 0; c < NCTX; c++)
                    if (idx == 6'(c)) reg_rdata = 32'(thr_q[c]);
            end
            RGN_CLAIM: begin
                for (int c = 0; c < NCTX; c++)
                    if (idx == 6'(c)) reg_rdata = 32'(best_id[c]);
            end
            default: reg_rdata = '0;
        endcase
    end

    p_single_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));

    p_complete_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (complete_vec != '0) |-> cmp_wr);
endmodule

// File: tb/test_plic_core.sv
module test_plic_core;
    localparam int NS = 10;
    localparam int NC = 9;
    localparam int QD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS:1]   src = '0;
    logic          we = 1'b0, re = 1'b0;
    logic [8:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [NC-1:0] irq_a, irq_b;
    logic [31:0]   rd_a, rd_b;

    always #2.5 clk = ~clk;

    plic_core #(.NSRC(NS), .NCTX(NC), .PRIO_W(3), .QDEPTH(QD), .QUEUE_EDGES(1'b1)) i_plic_core (
        .clk(clk), .rst_n(rst_n), .src_i(src), .irq_o(irq_a), .reg_we(we), .reg_re(re),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd_a));
    plic_core #(.NSRC(NS), .NCTX(NC), .PRIO_W(3), .QDEPTH(QD), .QUEUE_EDGES(1'b0)) i_plic_core_drop (
        .clk(clk), .rst_n(rst_n), .src_i(src), .irq_o(irq_b), .reg_we(we), .reg_re(re),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd_b));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string cur_req = "R1";

    // reference model state; index 0 = queue instance, 1 = drop instance
    int m_prio [NS+1];
    int m_edge [NS+1];
    int m_en   [NC][NS+1];
    int m_thr  [NC];
    int m_st   [2][NS+1];   // 0 idle, 1 pending, 2 claimed
    int m_cnt  [2][NS+1];
    int m_prev [NS+1];
    int m_irq  [2][NC];

    function automatic int a_prio(int s);  return s;       endfunction
    function automatic int a_en(int c);    return 128 + c; endfunction
    function automatic int a_thr(int c);   return 192 + c; endfunction
    function automatic int a_claim(int c); return 256 + c; endfunction

    function automatic int best(int m, int c);
        int b = 0;
        int bp = 0;
        for (int s = 1; s <= NS; s++)
            if (m_st[m][s] == 1 && m_en[c][s] != 0 && m_prio[s] > m_thr[c] && m_prio[s] > bp) begin
                b = s;
                bp = m_prio[s];
            end
        return b;
    endfunction

    function automatic int exp_rd(int m);
        int r = 0;
        int g = int'(addr) / 64;
        int i = int'(addr) % 64;
        case (g)
            0: if (i >= 1 && i <= NS) r = m_prio[i];
            1: begin
                if (i == 0) for (int s = 1; s <= NS; s++) if (m_st[m][s] == 1) r |= (1 << s);
                if (i == 1) for (int s = 1; s <= NS; s++) if (m_edge[s] != 0) r |= (1 << s);
            end
            2: if (i < NC) for (int s = 1; s <= NS; s++) if (m_en[i][s] != 0) r |= (1 << s);
            3: if (i < NC) r = m_thr[i];
            4: if (i < NC) r = best(m, i);
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        int g = int'(addr) / 64;
        int i = int'(addr) % 64;
        int inext [2][NC];
        for (int m = 0; m < 2; m++) begin
            int cl = 0;
            int cp = 0;
            for (int c = 0; c < NC; c++) inext[m][c] = (best(m, c) != 0) ? 1 : 0;
            if (re && g == 4 && i < NC) cl = best(m, i);
            if (we && g == 4 && i < NC && wdata >= 1 && wdata <= NS && m_en[i][int'(wdata)] != 0) cp = int'(wdata);
            for (int s = 1; s <= NS; s++) begin
                int rise = (src[s] && m_prev[s] == 0) ? 1 : 0;
                int trig = (m_edge[s] != 0) ? rise : int'(src[s]);
                case (m_st[m][s])
                    0: if (trig != 0) m_st[m][s] = 1;
                    1: if (cl == s) m_st[m][s] = 2;
                    default: begin
                        if (m_edge[s] != 0 && m == 0 && rise != 0 && m_cnt[m][s] < QD) m_cnt[m][s]++;
                        if (cp == s) begin
                            if (m_edge[s] == 0) m_st[m][s] = src[s] ? 1 : 0;
                            else if (m_cnt[m][s] > 0) begin m_st[m][s] = 1; m_cnt[m][s]--; end
                            else m_st[m][s] = 0;
                        end
                    end
                endcase
            end
        end
        for (int s = 1; s <= NS; s++) m_prev[s] = int'(src[s]);
        if (we) begin
            if (g == 0 && i >= 1 && i <= NS) m_prio[i] = int'(wdata[2:0]);
            if (g == 1 && i == 1) for (int s = 1; s <= NS; s++) m_edge[s] = int'(wdata[s]);
            if (g == 2 && i < NC) for (int s = 1; s <= NS; s++) m_en[i][s] = int'(wdata[s]);
            if (g == 3 && i < NC) m_thr[i] = int'(wdata[2:0]);
        end
        for (int m = 0; m < 2; m++) for (int c = 0; c < NC; c++) m_irq[m][c] = inext[m][c];
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic cyc();
        #1;
        for (int c = 0; c < NC; c++) begin
            chk("R10 irq queue-inst", int'(irq_a[c]), m_irq[0][c]);
            chk("R10 irq drop-inst",  int'(irq_b[c]), m_irq[1][c]);
        end
        if (re) begin
            chk({cur_req, " rdata queue-inst"}, int'(rd_a), exp_rd(0));
            chk({cur_req, " rdata drop-inst"},  int'(rd_b), exp_rd(1));
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        we = 1'b1; addr = 9'(a); wdata = 32'(d);
        cyc();
        we = 1'b0;
    endtask

    task automatic rd(int a, int exp_a, int exp_b, string req);
        cur_req = req;
        re = 1'b1; addr = 9'(a);
        #1;
        chk({req, " direct read queue-inst"}, int'(rd_a), exp_a);
        chk({req, " direct read drop-inst"},  int'(rd_b), exp_b);
        cyc();
        re = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) cyc();
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        report();
    end

    initial begin
        for (int s = 0; s <= NS; s++) begin
            m_prio[s] = 0; m_edge[s] = 0; m_prev[s] = 0;
            for (int m = 0; m < 2; m++) begin m_st[m][s] = 0; m_cnt[m][s] = 0; end
            for (int c = 0; c < NC; c++) m_en[c][s] = 0;
        end
        for (int c = 0; c < NC; c++) begin
            m_thr[c] = 0; m_irq[0][c] = 0; m_irq[1][c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq queue-inst", int'(irq_a), 0);
        chk("R1 irq drop-inst",  int'(irq_b), 0);
        rd(a_claim(0), 0, 0, "R1");
        rd(a_prio(2), 0, 0, "R1");
        rd(64, 0, 0, "R1");

        // R11: program the map and read it back
        wr(a_prio(1), 2); wr(a_prio(2), 5); wr(a_prio(3), 5); wr(a_prio(4), 1);
        wr(a_prio(5), 7); wr(a_prio(6), 3); wr(a_prio(7), 0); wr(a_prio(9), 4);
        wr(65, 32'h0000_0700);            // sources 8,9,10 edge
        wr(a_en(0), 32'h0000_07FF);       // bit 0 must be dropped
        wr(a_en(1), 32'h0000_0012);       // sources 1 and 4
        wr(a_en(2), 32'h0000_07FE);
        wr(a_thr(1), 1); wr(a_thr(2), 4);
        rd(a_prio(3), 5, 5, "R11");
        rd(a_en(0), 32'h7FE, 32'h7FE, "R11");
        rd(a_thr(2), 4, 4, "R11");
        rd(65, 32'h700, 32'h700, "R11");
        rd(300, 0, 0, "R11");

        // level lines: 2,3 (prio 5 tie), 4 (prio 1), 7 (prio 0)
        src[2] = 1; src[3] = 1; src[4] = 1; src[7] = 1;
        idle(3);
        rd(64, 32'h9C, 32'h9C, "R5");                 // pending bits 2,3,4,7
        rd(a_claim(1), 0, 0, "R4");                   // s4 prio 1 not above thr 1
        rd(a_claim(3), 0, 0, "R2");                   // nothing enabled
        rd(a_claim(2), 2, 2, "R3");                   // tie -> lowest id
        rd(a_claim(0), 3, 3, "R3");
        rd(a_claim(0), 4, 4, "R3");
        rd(a_claim(0), 0, 0, "R4");                   // s7 prio 0 never
        idle(2);
        rd(64, 32'h80, 32'h80, "R5");                 // claimed lines held high stay unpended

        src[2] = 0;
        wr(a_claim(0), 2); idle(1);
        rd(64, 32'h80, 32'h80, "R6");                 // s2 low -> idle
        wr(a_claim(1), 3); idle(1);                   // s3 not enabled for ctx 1
        rd(a_claim(0), 0, 0, "R9");
        wr(a_claim(0), 3);
        rd(a_claim(0), 3, 3, "R6");                   // line high -> replay
        wr(a_claim(0), 4);
        rd(a_claim(0), 4, 4, "R6");
        src[3] = 0; src[4] = 0; src[7] = 0;
        wr(a_claim(0), 3); wr(a_claim(0), 4); idle(2);
        rd(64, 32'h80, 32'h80, "R6");                 // s7 stays pending (prio 0)

        // edge source 9 (prio 4)
        src[9] = 1; idle(1); src[9] = 0; idle(1);
        src[9] = 1; idle(1); src[9] = 0; idle(1);     // merged while pending
        rd(a_claim(0), 9, 9, "R8");
        for (int k = 0; k < 6; k++) begin
            src[9] = 1; idle(1); src[9] = 0; idle(1);
        end
        for (int k = 0; k < QD; k++) begin
            wr(a_claim(0), 9);
            rd(a_claim(0), 9, 0, "R7");               // queue replays, drop does not
        end
        wr(a_claim(0), 9); idle(1);
        rd(a_claim(0), 0, 0, "R7");                   // saturated at QDEPTH
        rd(64, 32'h80, 32'h80, "R8");

        // threshold change and irq timing
        src[5] = 1; idle(1);
        chk("R10 irq not yet", int'(irq_a[2]), 0);
        idle(1);
        chk("R10 irq raised", int'(irq_a[2]), 1);
        wr(a_thr(2), 7); idle(1);
        chk("R4 masked by threshold", int'(irq_a[2]), 0);
        rd(a_claim(2), 0, 0, "R4");
        rd(a_claim(0), 5, 5, "R3");
        idle(2);
        chk("R5 irq low after claim", int'(irq_a[0]), 0);
        src[5] = 0;
        wr(a_claim(0), 5); idle(3);

        report();
    end
endmodule